// File: doc/BRIEF.md
# Bus Transfer Acknowledge Monitor

This block watches the cycles that an on-chip master drives onto the external bus. When such a transfer starts, the monitor waits for the external slave to acknowledge it. If the wait goes past a programmable number of bus clocks, the monitor ends the cycle itself. It does so by returning a one-cycle transfer error acknowledge to the master. The master's bus logic then treats the access as a bus error and no longer hangs on a slave that is missing or stalled.

Cycles that stay inside the chip are not watched. The whole function can be switched off with an enable bit. The wait limit is a field that is copied when each transfer starts. While a transfer is being watched, a second start strobe is ignored, because only one external cycle can be outstanding at a time.

Top module: `bus_ack_monitor`

## Requirements
- R1: After reset the monitor is idle and `xfer_err_o` is low.
- R2: A start (`xfer_start_i`=1 with `xfer_ext_i`=1 and `mon_en_i`=1) in cycle 0 with limit value L, followed by no acknowledge in cycles 1 to L+1, drives `xfer_err_o` high for exactly one cycle, in cycle L+2. This includes L=0.
- R3: An acknowledge (`xfer_ack_i`=1) in any cycle from 1 to L ends the watched transfer, and no error follows.
- R4: An acknowledge in cycle L+1 arrives in the same cycle that the count expires. The acknowledge wins and no error is produced.
- R5: A start with `xfer_ext_i`=0 marks an internal-only cycle. It is ignored and never leads to an error.
- R6: While `mon_en_i` is 0 no error is produced. A start seen while the monitor is disabled is ignored. If the enable is dropped during a watched transfer, that transfer is abandoned without an error.
- R7: The limit is taken from `limit_i` only in the start cycle. Changes to `limit_i` later in the transfer do not move the error cycle.
- R8: An acknowledge while the monitor is idle is ignored, and this includes an acknowledge that arrives after the error has been issued. A start strobe during a watched transfer is also ignored and does not restart the count.
- R9: After the error pulse the monitor is idle again. A start in the same cycle as the error pulse begins a new watched transfer, timed from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xfer_start_i | input | 1 | One-cycle strobe marking the start of a transfer |
| xfer_ext_i | input | 1 | High when the starting transfer targets the external bus |
| xfer_ack_i | input | 1 | Transfer acknowledge from the external slave |
| mon_en_i | input | 1 | Monitor enable from the control register |
| limit_i | input | LIMIT_W | Timeout limit L from the control register, in bus clocks |
| xfer_err_o | output | 1 | Transfer error acknowledge, a one-cycle pulse |

## Verification
Number the start cycle 0. An acknowledge driven in cycle j is sampled at the end of cycle j. A missing acknowledge produces the error as a registered output, so the error is visible only in cycle L+2. An acknowledge in cycle L+1 or earlier must leave the output low in every cycle. Each scenario drives its inputs and reads `xfer_err_o` at the falling clock edge of every cycle, starting at cycle 1 and continuing through at least cycle L+2. It compares the output against a pulse expected in cycle L+2 only, so an error that comes early, late or lasts too long is caught in the cycle where it happens. The limit input is inverted after every start, so a design that reads it late moves the pulse and fails the check.

// File: rtl/bus_ack_monitor.sv
module bus_ack_monitor #(
  parameter int LIMIT_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               xfer_start_i,
  input  logic               xfer_ext_i,
  input  logic               xfer_ack_i,
  input  logic               mon_en_i,
  input  logic [LIMIT_W-1:0] limit_i,
  output logic               xfer_err_o
);
  localparam logic [LIMIT_W-1:0] CNT_ZERO = '0;

  logic               busy_q;
  logic [LIMIT_W-1:0] cnt_q;
  logic               err_q;

  wire take   = xfer_start_i & xfer_ext_i & mon_en_i & ~busy_q;
  wire at_end = (cnt_q == CNT_ZERO);
  wire expire = busy_q & mon_en_i & ~xfer_ack_i & at_end;
  wire finish = busy_q & (xfer_ack_i | ~mon_en_i | at_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= CNT_ZERO;
      err_q  <= 1'b0;
    end else begin
      err_q <= expire;
      if (take) begin
        busy_q <= 1'b1;
        cnt_q  <= limit_i;
      end else if (finish) begin
        busy_q <= 1'b0;
        cnt_q  <= CNT_ZERO;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign xfer_err_o = err_q;
endmodule

module bus_ack_monitor_chk #(
  parameter int LIMIT_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               xfer_start_i,
  input logic               xfer_ext_i,
  input logic               xfer_ack_i,
  input logic               mon_en_i,
  input logic [LIMIT_W-1:0] limit_i,
  input logic               xfer_err_o,
  input logic               busy_q
);
  // R2
  err_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_err_o |=> !xfer_err_o);

  // R4
  err_no_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_err_o |-> !$past(xfer_ack_i));

  // R6
  err_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_err_o |-> $past(mon_en_i));

  // R8
  err_after_watch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_err_o |-> $past(busy_q));

  // R5
  watch_from_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(xfer_start_i && xfer_ext_i && mon_en_i));

  // R9
  idle_after_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_err_o |-> !busy_q || $past(xfer_start_i));
endmodule

bind bus_ack_monitor bus_ack_monitor_chk #(.LIMIT_W(LIMIT_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .xfer_start_i(xfer_start_i),
  .xfer_ext_i(xfer_ext_i), .xfer_ack_i(xfer_ack_i), .mon_en_i(mon_en_i),
  .limit_i(limit_i), .xfer_err_o(xfer_err_o), .busy_q(busy_q)
);

// File: tb/bus_ack_monitor_tb.sv
module bus_ack_monitor_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, ext = 1'b0, ack = 1'b0, en = 1'b1;
  logic [W-1:0] lim = '0;
  logic err;
  int total = 0, fails = 0;

  always #4 clk = ~clk;

  bus_ack_monitor #(.LIMIT_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .xfer_start_i(start), .xfer_ext_i(ext),
    .xfer_ack_i(ack), .mon_en_i(en), .limit_i(lim), .xfer_err_o(err)
  );

  task automatic check(input logic got, input logic exp, input string tag, input int cyc);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: xfer_err_o=%b expected %b", tag, cyc, got, exp);
    end
  endtask

  // Caller stands at a falling edge; start is raised in this cycle (cycle 0).
  task automatic run_xfer(input logic x_ext, input logic en0, input int l,
                          input int ack_at, input int dis_at, input int again_at,
                          input logic exp_err, input int last, input string tag);
    start = 1'b1; ext = x_ext; en = en0; ack = 1'b0; lim = W'(l);
    for (int j = 1; j <= last; j++) begin
      @(negedge clk);
      start = (again_at == j);
      ext   = 1'b1;
      lim   = ~W'(l);
      ack   = (ack_at == j);
      en    = en0 && !(dis_at != 0 && j >= dis_at);
      check(err, exp_err && (j == l + 2), tag, j);
    end
  endtask

  task automatic t_reset;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(err, 1'b0, "R1", i);
    end
  endtask

  task automatic t_timeout;
    run_xfer(1, 1, 3, 0, 0, 0, 1, 7, "R2");
    run_xfer(1, 1, 0, 0, 0, 0, 1, 4, "R2_zero");
  endtask

  task automatic t_early_ack;
    run_xfer(1, 1, 5, 2, 0, 0, 0, 9, "R3");
    run_xfer(1, 1, 4, 1, 0, 0, 0, 8, "R3_first");
  endtask

  task automatic t_edge_ack;
    run_xfer(1, 1, 4, 5, 0, 0, 0, 8, "R4");
    run_xfer(1, 1, 0, 1, 0, 0, 0, 4, "R4_zero");
  endtask

  task automatic t_internal;
    run_xfer(0, 1, 2, 0, 0, 0, 0, 6, "R5");
  endtask

  task automatic t_disabled;
    run_xfer(1, 0, 2, 0, 0, 0, 0, 6, "R6_off");
    run_xfer(1, 1, 4, 0, 2, 0, 0, 8, "R6_mid");
    run_xfer(1, 1, 1, 0, 0, 0, 1, 5, "R6_back_on");
  endtask

  task automatic t_limit_latch;
    run_xfer(1, 1, 6, 0, 0, 0, 1, 10, "R7");
  endtask

  task automatic t_ignored;
    run_xfer(1, 1, 2, 5, 0, 0, 1, 8, "R8_late_ack");
    run_xfer(1, 1, 5, 0, 0, 2, 1, 9, "R8_restart");
    run_xfer(1, 1, 1, 0, 0, 0, 1, 5, "R8_after");
  endtask

  task automatic t_back_to_back;
    run_xfer(1, 1, 1, 0, 0, 0, 1, 3, "R9_first");
    run_xfer(1, 1, 2, 0, 0, 0, 1, 6, "R9_second");
  endtask

  initial begin
    #(8 * 100000);
    fails++; total++;
    $display("FAIL watchdog: run did not finish, got hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(err, 1'b0, "R1", -1);
    rst_n = 1'b1;
    t_reset();
    t_timeout();
    t_early_ack();
    t_edge_ack();
    t_internal();
    t_disabled();
    t_limit_latch();
    t_ignored();
    t_back_to_back();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule